// File: doc/BRIEF.md
# Multiplexed Acquisition Channel Sequencer

This block steps an analog input multiplexer through a programmable number of channels and paces one external converter. Each time it selects a channel, it drives that channel's address and a per-channel amplifier gain code read from a small gain table. It then runs one of two timing schemes. The first waits a settle interval and then pulses convert start. The second holds a track/hold stage in track for an acquire interval, drops it to hold together with convert start, and moves the multiplexer on at that same edge, so the analog settling overlaps the conversion.

When the converter reports completion, the block presents the result word tagged with the channel that was converted. For converters that carry a digital filter, the block can run and discard a set number of conversions after every channel selection and keep only the next one. A level enable starts the round-robin sequence at channel 0. Dropping the enable lets a pending conversion complete and then stops the sequence.

Top module: `mux_acq_sequencer`

## Requirements
- R1: `mux_addr` and `pga_gain` only change at the same clock edge, and after that edge `pga_gain` equals the 3-bit gain table entry of the new address. The table is written through `gtab_we`/`gtab_addr`/`gtab_data`, and a write reaches `pga_gain` only at the next selection of that channel.
- R2: With `cfg_sh_mode`=0, `track` stays low and `conv_start` is a one-cycle pulse that rises exactly `cfg_settle`+1 clock edges after the edge that selected the channel or completed the previous conversion.
- R3: With `cfg_sh_mode`=1, `track` rises at the edge that selects or restarts a channel. It falls exactly `cfg_acq`+1 edges later, at the same edge where `conv_start` rises, and at that edge the mux address and gain move to the next channel when the result is to be kept.
- R4: Let C be the number of edges from the rise of `conv_start` to the edge that samples `conv_done`. Then `track` rises every `cfg_acq`+1+C cycles in track/hold mode, and `conv_start` rises every `cfg_settle`+1+C cycles in settle mode.
- R5: Channels are visited in the order 0, 1, …, `cfg_last_ch` and then wrap to 0, so M = `cfg_last_ch`+1 channels (1 to 16) share the conversion rate equally.
- R6: A kept result appears as a one-cycle `res_valid` at the edge that samples `conv_done`. It carries `res_data` = `conv_data` and `res_chan` = the channel that was converted.
- R7: With `cfg_discard`=D, the first D conversions after each channel selection run on the same channel and raise no `res_valid`. The (D+1)th conversion is kept and then the sequence advances. D=0 keeps every result.
- R8: A `conv_done` that arrives while no conversion is pending produces no result and leaves the timing unchanged.
- R9: A rising `enable` from idle starts at channel 0 with gain table entry 0. If `enable` drops while a conversion is pending, that result is still delivered. Once the sequence has stopped, no further `conv_start` occurs and `track` is low.
- R10: After reset, `mux_addr`, `pga_gain`, `track`, `conv_start` and `res_valid` are 0, and every gain table entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the sequence while high |
| cfg_sh_mode | input | 1 | 1: track/hold timing, 0: settle-then-convert timing |
| cfg_last_ch | input | 4 | Highest channel visited (M-1) |
| cfg_settle | input | 8 | Settle budget in cycles (minus one) |
| cfg_acq | input | 8 | Acquire budget in cycles (minus one) |
| cfg_discard | input | 3 | Conversions dropped after each selection |
| gtab_we | input | 1 | Gain table write strobe |
| gtab_addr | input | 4 | Gain table write index |
| gtab_data | input | 3 | Gain code to store |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result word |
| mux_addr | output | 4 | Multiplexer channel address |
| pga_gain | output | 3 | Amplifier gain code |
| track | output | 1 | 1 = track, 0 = hold |
| conv_start | output | 1 | One-cycle convert command |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Result word |
| res_chan | output | 4 | Channel tag of the result |

## Verification
A timer that reloads wrongly shows up at once as a `conv_start` or a falling `track` one edge off its budget, on the very first channel after enable. A wrong channel counter or discard counter shows up within one channel period, either as an out-of-order `mux_addr` or as a `res_chan` tag that repeats or skips. A gain register updated away from the address edge appears as a `pga_gain` that disagrees with the table in the cycle after a switch. The bench sweeps both timing modes, channel counts 1, 2, 3, 4 and 16, and discard counts 0, 1 and 2. Every expected edge is computed from the budgets and the converter delay.

// File: rtl/mux_acq_pkg.sv
package mux_acq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_ACQ    = 2'd2,
    SQ_CONV   = 2'd3
  } seq_state_e;

  // Round-robin successor: wrap to zero after the last active channel.
  function automatic int unsigned next_chan(input int unsigned cur,
                                            input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  // States in which a budget timer is running toward a convert command.
  function automatic logic is_waiting(input seq_state_e st);
    return (st == SQ_SETTLE) || (st == SQ_ACQ);
  endfunction

endpackage

// File: rtl/acq_gain_table.sv
module acq_gain_table #(
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CHAN_W-1:0] waddr,
  input  logic [GAIN_W-1:0] wdata,
  input  logic [CHAN_W-1:0] raddr,
  output logic [GAIN_W-1:0] rdata
);
  localparam int DEPTH = 1 << CHAN_W;

  logic [GAIN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && (waddr == CHAN_W'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acq_interval_timer.sv
module acq_interval_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic              expired
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/acq_chan_stepper.sv
module acq_chan_stepper
  import mux_acq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 3,
  parameter int DISC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              burn,
  input  logic [CHAN_W-1:0] last_ch,
  input  logic [DISC_W-1:0] discard_n,
  output logic [CHAN_W-1:0] tbl_raddr,
  input  logic [GAIN_W-1:0] tbl_rdata,
  output logic [CHAN_W-1:0] chan,
  output logic [GAIN_W-1:0] gain,
  output logic              keep
);
  logic [CHAN_W-1:0] chan_q;
  logic [GAIN_W-1:0] gain_q;
  logic [DISC_W-1:0] disc_q;
  logic              sel;

  assign sel       = restart || advance;
  assign tbl_raddr = restart ? '0
                   : CHAN_W'(next_chan(int'(chan_q), int'(last_ch)));

  // Address and gain share one enable so they always move together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      gain_q <= '0;
    end else if (sel) begin
      chan_q <= tbl_raddr;
      gain_q <= tbl_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      disc_q <= '0;
    else if (sel)
      disc_q <= discard_n;
    else if (burn && (disc_q != '0))
      disc_q <= disc_q - 1'b1;
  end

  assign chan = chan_q;
  assign gain = gain_q;
  assign keep = (disc_q == '0);
endmodule

// File: rtl/mux_acq_sequencer.sv
module mux_acq_sequencer
  import mux_acq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 3,
  parameter int DATA_W = 12,
  parameter int TIME_W = 8,
  parameter int DISC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_sh_mode,
  input  logic [CHAN_W-1:0] cfg_last_ch,
  input  logic [TIME_W-1:0] cfg_settle,
  input  logic [TIME_W-1:0] cfg_acq,
  input  logic [DISC_W-1:0] cfg_discard,
  input  logic              gtab_we,
  input  logic [CHAN_W-1:0] gtab_addr,
  input  logic [GAIN_W-1:0] gtab_data,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [CHAN_W-1:0] mux_addr,
  output logic [GAIN_W-1:0] pga_gain,
  output logic              track,
  output logic              conv_start,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CHAN_W-1:0] res_chan
);
  seq_state_e state_q, state_d;

  logic              tmr_expired;
  logic              tmr_load;
  logic [TIME_W-1:0] tmr_load_val;
  logic              keep;
  logic [CHAN_W-1:0] tbl_raddr;
  logic [GAIN_W-1:0] tbl_rdata;

  // Named internal events, also observed by the bound checker.
  logic ev_begin, ev_start, ev_abort, ev_done, ev_rerun;
  logic ev_advance, ev_burn, ev_switch;

  logic              conv_start_q, track_q, conv_keep_q, res_valid_q;
  logic [CHAN_W-1:0] conv_chan_q, res_chan_q;
  logic [DATA_W-1:0] res_data_q;

  acq_gain_table #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) u_gtab (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gtab_we),
    .waddr (gtab_addr),
    .wdata (gtab_data),
    .raddr (tbl_raddr),
    .rdata (tbl_rdata)
  );

  acq_interval_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .expired  (tmr_expired)
  );

  acq_chan_stepper #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W), .DISC_W(DISC_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ev_begin),
    .advance   (ev_advance),
    .burn      (ev_burn),
    .last_ch   (cfg_last_ch),
    .discard_n (cfg_discard),
    .tbl_raddr (tbl_raddr),
    .tbl_rdata (tbl_rdata),
    .chan      (mux_addr),
    .gain      (pga_gain),
    .keep      (keep)
  );

  always_comb begin
    ev_begin   = (state_q == SQ_IDLE) && enable;
    ev_start   = is_waiting(state_q) && enable && tmr_expired;
    ev_abort   = is_waiting(state_q) && !enable;
    ev_done    = (state_q == SQ_CONV) && conv_done;
    ev_rerun   = ev_done && enable;
    // Track/hold mode moves on at the hold edge; settle mode after completion.
    ev_advance = (ev_start && keep && cfg_sh_mode)
              || (ev_done && conv_keep_q && !cfg_sh_mode);
    ev_burn    = ev_start && !keep;
    ev_switch  = ev_begin || ev_advance;
    tmr_load     = ev_begin || ev_rerun;
    tmr_load_val = cfg_sh_mode ? cfg_acq : cfg_settle;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:
        if (enable) state_d = cfg_sh_mode ? SQ_ACQ : SQ_SETTLE;
      SQ_SETTLE, SQ_ACQ:
        if (!enable)          state_d = SQ_IDLE;
        else if (tmr_expired) state_d = SQ_CONV;
      SQ_CONV:
        if (conv_done)
          state_d = !enable ? SQ_IDLE : (cfg_sh_mode ? SQ_ACQ : SQ_SETTLE);
      default:
        state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start_q <= 1'b0;
      track_q      <= 1'b0;
    end else begin
      conv_start_q <= ev_start;
      if (ev_begin || ev_rerun)
        track_q <= cfg_sh_mode;
      else if (ev_start || ev_abort)
        track_q <= 1'b0;
    end
  end

  // Tag and keep decision are fixed when the conversion is launched.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_keep_q <= 1'b0;
      conv_chan_q <= '0;
    end else if (ev_start) begin
      conv_keep_q <= keep;
      conv_chan_q <= mux_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
      res_chan_q  <= '0;
    end else begin
      res_valid_q <= ev_done && conv_keep_q;
      if (ev_done && conv_keep_q) begin
        res_data_q <= conv_data;
        res_chan_q <= conv_chan_q;
      end
    end
  end

  assign conv_start = conv_start_q;
  assign track      = track_q;
  assign res_valid  = res_valid_q;
  assign res_data   = res_data_q;
  assign res_chan   = res_chan_q;
endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker #(
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 3,
  parameter int TIME_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cfg_sh_mode,
  input logic [CHAN_W-1:0] cfg_last_ch,
  input logic [TIME_W-1:0] cfg_settle,
  input logic [TIME_W-1:0] cfg_acq,
  input logic              conv_done,
  input logic [CHAN_W-1:0] mux_addr,
  input logic [GAIN_W-1:0] pga_gain,
  input logic              track,
  input logic              conv_start,
  input logic              res_valid,
  input logic              ev_switch,
  input logic              tmr_load
);
  // Cycles since the budget timer was last loaded, saturating.
  logic [TIME_W:0] since_load;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_load <= '1;
    else if (tmr_load)
      since_load <= '0;
    else if (since_load != '1)
      since_load <= since_load + 1'b1;
  end

  AST_GAIN_MOVES_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pga_gain) |-> $past(ev_switch)); // R1
  AST_ADDR_MOVES_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mux_addr) |-> $past(ev_switch)); // R1
  AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !cfg_sh_mode) |-> (since_load == ((TIME_W+1)'(cfg_settle) + 1'b1))); // R2
  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && cfg_sh_mode) |-> (since_load == ((TIME_W+1)'(cfg_acq) + 1'b1))); // R3
  AST_HOLD_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(track) && $past(enable)) |-> conv_start); // R3
  AST_ROUND_ROBIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_switch |=> (mux_addr == '0 || mux_addr == $past(mux_addr) + 1'b1)); // R5
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_switch && $stable(cfg_last_ch)) |=> (mux_addr <= cfg_last_ch)); // R5
  AST_RESULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done)); // R8
  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(enable)); // R9
endmodule

bind mux_acq_sequencer acq_seq_checker #(
  .CHAN_W (CHAN_W),
  .GAIN_W (GAIN_W),
  .TIME_W (TIME_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cfg_sh_mode (cfg_sh_mode),
  .cfg_last_ch (cfg_last_ch),
  .cfg_settle  (cfg_settle),
  .cfg_acq     (cfg_acq),
  .conv_done   (conv_done),
  .mux_addr    (mux_addr),
  .pga_gain    (pga_gain),
  .track       (track),
  .conv_start  (conv_start),
  .res_valid   (res_valid),
  .ev_switch   (ev_switch),
  .tmr_load    (tmr_load)
);

// File: tb/mux_acq_sequencer_bench.sv
`timescale 1ns/1ps
module mux_acq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        cfg_sh_mode;
  logic [3:0]  cfg_last_ch;
  logic [7:0]  cfg_settle;
  logic [7:0]  cfg_acq;
  logic [2:0]  cfg_discard;
  logic        gtab_we;
  logic [3:0]  gtab_addr;
  logic [2:0]  gtab_data;
  logic        conv_done;
  logic [11:0] conv_data;
  logic [3:0]  mux_addr;
  logic [2:0]  pga_gain;
  logic        track;
  logic        conv_start;
  logic        res_valid;
  logic [11:0] res_data;
  logic [3:0]  res_chan;

  always #2 clk = ~clk;

  mux_acq_sequencer u_mux_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_sh_mode(cfg_sh_mode),
    .cfg_last_ch(cfg_last_ch), .cfg_settle(cfg_settle), .cfg_acq(cfg_acq),
    .cfg_discard(cfg_discard), .gtab_we(gtab_we), .gtab_addr(gtab_addr),
    .gtab_data(gtab_data), .conv_done(conv_done), .conv_data(conv_data),
    .mux_addr(mux_addr), .pga_gain(pga_gain), .track(track),
    .conv_start(conv_start), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model of the configuration and of the expected sequence.
  logic [2:0] tab [16];
  bit m_sh;
  int m_S, m_A, m_L, m_D, m_last;
  int cyc = 0;
  bit m_run = 0, pend = 0, upd = 0, done_fired = 0, keep_c = 0;
  bit req_start = 0, req_spur = 0, spur_chk = 0;
  int req_stop = 0, stop_at = 0;
  int t_ref = 0, t_prev_rise = 0, t_prev_start = 0;
  int m_ch = 0, m_disc = 0, conv_ch = 0, nxt_ch = 0, cd = 0, seq = 0;
  int n_res = 0, n_drop = 0;
  logic [11:0] exp_data;
  logic p_track = 1'b0;

  always @(negedge clk) begin
    cyc++;
    conv_done = 1'b0;
    if (upd) begin upd = 0; m_ch = nxt_ch; end

    // Result of the conversion whose completion was sampled at the last edge.
    if (done_fired) begin
      done_fired = 0;
      pend = 0;
      if (keep_c) begin
        chk(res_valid && res_chan == 4'(conv_ch) && res_data == exp_data, "R6",
            int'(res_data), int'(exp_data));
        n_res++;
        if (stop_at > 0 && n_res == stop_at) begin
          enable = 1'b0;
          m_run = 0;
        end
      end else begin
        chk(!res_valid, "R7", int'(res_valid), 0);
        n_drop++;
      end
    end else if (spur_chk) begin
      spur_chk = 0;
      chk(!res_valid, "R8", int'(res_valid), 0);
    end else if (res_valid) begin
      chk(1'b0, "R8", 1, 0);
    end

    // Converter countdown: completion driven so it is sampled L+1 edges after start.
    if (pend && cd > 0) begin
      cd--;
      if (cd == 0) begin
        conv_done = 1'b1;
        done_fired = 1;
        if (m_run) t_ref = cyc + 1;
        if (!m_sh && keep_c) upd = 1;
      end
    end

    if (conv_start) begin
      if (!m_run) begin
        chk(1'b0, "R9", 1, 0);
      end else begin
        if (m_sh) begin
          chk(cyc == t_ref + m_A + 1, "R3", cyc - t_ref, m_A + 1);
          chk(p_track && !track, "R3", int'(track), 0);
        end else begin
          chk(cyc == t_ref + m_S + 1, "R2", cyc - t_ref, m_S + 1);
          chk(!track, "R2", int'(track), 0);
          if (t_prev_start > 0)
            chk(cyc - t_prev_start == m_S + m_L + 2, "R4", cyc - t_prev_start, m_S + m_L + 2);
        end
      end
      t_prev_start = cyc;
      conv_ch = m_ch;
      keep_c = (m_disc == 0);
      nxt_ch = (m_ch >= m_last) ? 0 : m_ch + 1;
      if (keep_c) m_disc = m_D;
      else        m_disc--;
      if (m_sh && keep_c) m_ch = nxt_ch;
      seq++;
      exp_data = {4'(conv_ch), 8'(seq)};
      conv_data = exp_data;
      pend = 1;
      cd = m_L;
      if (req_stop == 1) begin
        req_stop = 0;
        enable = 1'b0;
        m_run = 0;
      end
    end

    if (!p_track && track) begin
      chk(m_sh && cyc == t_ref, "R3", cyc - t_ref, 0);
      if (t_prev_rise > 0)
        chk(cyc - t_prev_rise == m_A + m_L + 2, "R4", cyc - t_prev_rise, m_A + m_L + 2);
      t_prev_rise = cyc;
    end
    if (track && !m_sh) chk(1'b0, "R2", 1, 0);

    if (m_run || pend) begin
      chk(int'(mux_addr) == m_ch, "R5", int'(mux_addr), m_ch);
      chk(pga_gain == tab[mux_addr], "R1", int'(pga_gain), int'(tab[mux_addr]));
    end

    if (req_start) begin
      req_start = 0;
      enable = 1'b1;
      m_run = 1;
      m_ch = 0;
      m_disc = m_D;
      t_ref = cyc + 1;
      t_prev_rise = 0;
      t_prev_start = 0;
    end
    if (req_spur && !pend && !done_fired) begin
      req_spur = 0;
      conv_done = 1'b1;
      spur_chk = 1;
    end
    p_track = track;
  end

  task automatic write_tab(input int idx, input logic [2:0] code);
    @(negedge clk);
    gtab_we = 1'b1; gtab_addr = 4'(idx); gtab_data = code;
    @(negedge clk);
    gtab_we = 1'b0;
    tab[idx] = code;
  endtask

  task automatic run(input bit sh, input int last, input int s, input int a,
                     input int l, input int d, input int nres, input bit stop_pend,
                     input bit spur);
    @(negedge clk);
    cfg_sh_mode = sh; cfg_last_ch = 4'(last); cfg_settle = 8'(s);
    cfg_acq = 8'(a); cfg_discard = 3'(d);
    m_sh = sh; m_last = last; m_S = s; m_A = a; m_L = l; m_D = d;
    n_res = 0; n_drop = 0;
    stop_at = stop_pend ? 0 : nres;
    req_start = 1;
    repeat (3) @(negedge clk);
    chk(mux_addr == 4'd0 && pga_gain == tab[0], "R9", int'(mux_addr), 0);
    if (spur) begin
      while (n_res < 2) @(negedge clk);
      req_spur = 1;
    end
    while (n_res < nres) @(negedge clk);
    if (stop_pend) begin
      req_stop = 1;
      while (enable) @(negedge clk);
      while (pend || done_fired) @(negedge clk);
      @(negedge clk);
      chk(n_res == nres + 1, "R9", n_res, nres + 1);
    end
    begin
      int cs = 0;
      repeat (30) begin
        @(negedge clk);
        if (conv_start) cs++;
      end
      chk(cs == 0 && !track, "R9", cs, 0);
    end
    if (d > 0) chk(n_drop == d * n_res, "R7", n_drop, d * n_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) tab[i] = 3'd0;
    rst_n = 1'b0; enable = 1'b0; cfg_sh_mode = 1'b0; cfg_last_ch = 4'd0;
    cfg_settle = 8'd0; cfg_acq = 8'd0; cfg_discard = 3'd0;
    gtab_we = 1'b0; gtab_addr = 4'd0; gtab_data = 3'd0;
    conv_done = 1'b0; conv_data = 12'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mux_addr == 4'd0, "R10", int'(mux_addr), 0);
    chk(pga_gain == 3'd0, "R10", int'(pga_gain), 0);
    chk(!track && !conv_start && !res_valid, "R10", int'(track), 0);

    // Table still at reset values: every per-cycle gain check expects 0 (R10).
    run(1'b0, 1, 1, 0, 2, 0, 4, 1'b0, 1'b0);

    for (int i = 0; i < 16; i++) write_tab(i, 3'((i * 5 + 3) & 7));

    run(1'b0, 3, 3, 0, 5, 0, 10, 1'b1, 1'b1);   // settle mode, spurious done, stop while pending
    run(1'b1, 2, 0, 2, 4, 0, 9, 1'b1, 1'b0);    // track/hold mode, M=3
    run(1'b1, 0, 0, 0, 1, 0, 5, 1'b0, 1'b0);    // single channel
    run(1'b0, 15, 0, 0, 1, 0, 34, 1'b0, 1'b0);  // all 16 channels, wrap
    write_tab(2, 3'd6);                          // R1: takes effect on next selection
    run(1'b0, 1, 1, 0, 3, 2, 6, 1'b0, 1'b1);    // discard 2, settle mode
    run(1'b1, 2, 0, 1, 2, 1, 6, 1'b0, 1'b0);    // discard 1, track/hold mode

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule